// File: doc/BRIEF.md
# Paired-Register Double-Precision Operand Unit

This unit sits in the decode and register-read stage of a 32-bit RISC core. It handles the double-precision floating-point instruction group. Each 64-bit value lives in two 32-bit general-purpose registers. The second register of each operand is the first register plus one or plus two, chosen per operand by a 3-bit step mask in the instruction word. This lets a pair straddle the callee-saved even registers.

The unit decodes an instruction word while a decode-valid strobe is high. It reports the operation, the resolved register indices and the two assembled 64-bit source operands, all combinationally. An external arithmetic stage uses the operands. In the same cycle, that stage returns a 64-bit result with a write enable, or a comparison outcome with a valid strobe. The unit writes the result back as two 32-bit halves, or latches the comparison outcome in a flag register.

A configuration input selects 64-bit-register mode. In that mode every step bit must be clear, and each operand is a single register.

Top module: `dpr_pair_unit`

## Requirements
- R1: An instruction is recognised only when `dec_valid_i` is high and bits 31:26 equal 0x32. Otherwise `op_o` is 0 and `illegal_o` is 0. For a recognised instruction, the low byte selects the operation, reported on `op_o` as follows: 0x10 add → 1, 0x11 subtract → 2, 0x18 flag-if-equal → 3, 0x19 flag-if-not-equal → 4, 0x14 integer-to-double → 5, 0x15 double-to-integer → 6.
- R2: The first destination index comes from bits 25:21, the first A index from bits 20:16, and the first B index from bits 15:11.
- R3: Each 64-bit source operand has its second register in bits 63:32 and its first register in bits 31:0. A 64-bit result is stored the same way: bits 31:0 go to the first destination register and bits 63:32 to the second.
- R4: For add and subtract, a set bit 10 makes the second destination index the first plus 2, and a clear bit 10 makes it the first plus 1. Bit 9 does the same for source A, and bit 8 for source B.
- R5: A comparison requires bit 10 to be 0. Bits 9 and 8 give the A and B steps. It writes no register, even if `wr_en_i` is high, and it reports both destination indices as 0.
- R6: A conversion requires bits 15:11 and bit 8 to be 0. Bit 10 gives the destination step and bit 9 gives the A step. It reports source B indices of 0 and a source B operand of 0.
- R7: When `mode64_i` is high, any set bit among bits 10:8 is illegal. Otherwise every second index is reported as 0, the upper 32 bits of each operand read as 0, and a write stores only the lower 32 bits in the first destination register.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: `flag_o` takes `cmp_result_i` at the clock edge of a legal comparison that has `cmp_valid_i` high. At every other edge it holds its value.
- R10: With `wr_en_i` high on a legal add, subtract or conversion, both halves are written at the same clock edge. A source that reads a register being written in that cycle sees the new value combinationally.
- R11: The following are illegal: an unknown low byte, a set bit in a field the operation requires to be 0, and a second index above 31 in 32-bit mode. An illegal instruction raises `illegal_o`, reports `op_o` as 0, and writes neither a register nor the flag.
- R12: A synchronous active-high reset clears every register and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64_i | input | 1 | 64-bit-register mode select |
| insn_i | input | 32 | Instruction word |
| dec_valid_i | input | 1 | Instruction word is valid this cycle |
| wr_en_i | input | 1 | Result write enable from the arithmetic stage |
| wr_data_i | input | 64 | 64-bit result to write back |
| cmp_valid_i | input | 1 | Comparison outcome is valid |
| cmp_result_i | input | 1 | Comparison outcome |
| op_o | output | 3 | Decoded operation code (R1) |
| illegal_o | output | 1 | Illegal instruction |
| rd1_o | output | 5 | First destination index |
| rd2_o | output | 5 | Second destination index |
| ra1_o | output | 5 | First source A index |
| ra2_o | output | 5 | Second source A index |
| rb1_o | output | 5 | First source B index |
| rb2_o | output | 5 | Second source B index |
| src_a_o | output | 64 | Assembled source A operand |
| src_b_o | output | 64 | Assembled source B operand |
| flag_o | output | 1 | Comparison flag |

## Verification
Every destination index from 0 to 31 is written with both step values. This separates plus-one from plus-two pairing, the exact overflow boundary at 30 and 31, and the dropped write to register 0. Reads then sweep every A index with both steps, paired with a scattered B index and the opposite step. This shows that the A and B halves are not swapped or crossed, and that add and subtract decode apart. Further patterns cover the rest of the behaviour:
- Comparisons with equal and unequal operands, and a non-comparison cycle with the comparison strobe high, separate flag capture from flag hold.
- Conversions, 64-bit mode and reserved-bit violations are each followed by read-back of the registers a faulty write would have changed.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int IDXW  = $clog2(NREG);
    localparam int DLEN  = 2 * XLEN;

    localparam logic [5:0] GROUP_MAJOR = 6'h32;

    localparam logic [7:0] FN_ADD  = 8'h10;
    localparam logic [7:0] FN_SUB  = 8'h11;
    localparam logic [7:0] FN_ITOF = 8'h14;
    localparam logic [7:0] FN_FTOI = 8'h15;
    localparam logic [7:0] FN_FEQ  = 8'h18;
    localparam logic [7:0] FN_FNE  = 8'h19;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_FEQ  = 3'd3,
        OP_FNE  = 3'd4,
        OP_ITOF = 3'd5,
        OP_FTOI = 3'd6
    } dop_e;

    typedef struct packed {
        dop_e            op;
        logic            illegal;
        logic [IDXW-1:0] rd1;
        logic [IDXW-1:0] rd2;
        logic [IDXW-1:0] ra1;
        logic [IDXW-1:0] ra2;
        logic [IDXW-1:0] rb1;
        logic [IDXW-1:0] rb2;
        logic            wr_pair;
        logic            wr_flag;
    } dec_t;

    // first + 1 + step, one bit wider so overflow past the last register shows
    function automatic logic [IDXW:0] pair_next(logic [IDXW-1:0] first, logic step);
        return {1'b0, first} + (IDXW+1)'(1) + {{IDXW{1'b0}}, step};
    endfunction

endpackage

// File: rtl/dpr_decode.sv
module dpr_decode
    import dpr_pkg::*;
(
    input  logic        valid_i,
    input  logic        mode64_i,
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);

    logic [IDXW-1:0] f_d, f_a, f_b;
    logic [2:0]      steps;
    logic [7:0]      fn;
    logic            use_d, use_a, use_b, is_cmp, rsv_bad, fn_bad, m64_bad, ovf;
    logic            st_d, st_a, st_b;
    logic [IDXW:0]   nx_d, nx_a, nx_b;
    dop_e            op_raw;

    assign f_d   = insn_i[25:21];
    assign f_a   = insn_i[20:16];
    assign f_b   = insn_i[15:11];
    assign steps = insn_i[10:8];
    assign fn    = insn_i[7:0];

    always_comb begin
        use_d = 1'b0; use_a = 1'b0; use_b = 1'b0; is_cmp = 1'b0;
        st_d = 1'b0;  st_a = 1'b0;  st_b = 1'b0;
        rsv_bad = 1'b0; fn_bad = 1'b0; op_raw = OP_NONE;
        unique case (fn)
            FN_ADD, FN_SUB: begin
                op_raw = (fn == FN_ADD) ? OP_ADD : OP_SUB;
                use_d = 1'b1; use_a = 1'b1; use_b = 1'b1;
                st_d = steps[2]; st_a = steps[1]; st_b = steps[0];
            end
            FN_FEQ, FN_FNE: begin
                op_raw = (fn == FN_FEQ) ? OP_FEQ : OP_FNE;
                is_cmp = 1'b1; use_a = 1'b1; use_b = 1'b1;
                st_a = steps[1]; st_b = steps[0];
                rsv_bad = steps[2];
            end
            FN_ITOF, FN_FTOI: begin
                op_raw = (fn == FN_ITOF) ? OP_ITOF : OP_FTOI;
                use_d = 1'b1; use_a = 1'b1;
                st_d = steps[2]; st_a = steps[1];
                rsv_bad = steps[0] | (f_b != '0);
            end
            default: fn_bad = 1'b1;
        endcase
    end

    assign nx_d    = pair_next(f_d, st_d);
    assign nx_a    = pair_next(f_a, st_a);
    assign nx_b    = pair_next(f_b, st_b);
    assign m64_bad = mode64_i && (steps != 3'b000);
    assign ovf     = !mode64_i && ((use_d && nx_d[IDXW]) || (use_a && nx_a[IDXW]) ||
                                   (use_b && nx_b[IDXW]));

    always_comb begin
        dec_o = '0;
        if (valid_i && insn_i[31:26] == GROUP_MAJOR) begin
            dec_o.illegal = fn_bad | rsv_bad | m64_bad | ovf;
            dec_o.op      = dec_o.illegal ? OP_NONE : op_raw;
            dec_o.rd1     = use_d ? f_d : '0;
            dec_o.ra1     = use_a ? f_a : '0;
            dec_o.rb1     = use_b ? f_b : '0;
            dec_o.rd2     = (use_d && !mode64_i) ? nx_d[IDXW-1:0] : '0;
            dec_o.ra2     = (use_a && !mode64_i) ? nx_a[IDXW-1:0] : '0;
            dec_o.rb2     = (use_b && !mode64_i) ? nx_b[IDXW-1:0] : '0;
            dec_o.wr_pair = !dec_o.illegal && use_d;
            dec_o.wr_flag = !dec_o.illegal && is_cmp;
        end
    end

endmodule

// File: rtl/dpr_regfile.sv
module dpr_regfile
    import dpr_pkg::*;
#(
    parameter int ENTRIES = NREG,
    parameter int WIDTH   = XLEN,
    parameter int NRD     = 4,
    parameter int NWR     = 2,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i    [NWR],
    input  logic [AW-1:0]    waddr_i [NWR],
    input  logic [WIDTH-1:0] wdata_i [NWR],
    input  logic [AW-1:0]    raddr_i [NRD],
    output logic [WIDTH-1:0] rdata_o [NRD]
);

    logic [WIDTH-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (we_i[w] && waddr_i[w] != '0) mem[waddr_i[w]] <= wdata_i[w];
            end
        end
    end

    // read ports with same-cycle bypass; higher write port takes precedence
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        always_comb begin
            rdata_o[r] = mem[raddr_i[r]];
            for (int w = 0; w < NWR; w++) begin
                if (we_i[w] && waddr_i[w] == raddr_i[r]) rdata_o[r] = wdata_i[w];
            end
            if (raddr_i[r] == '0) rdata_o[r] = '0;
        end
    end

endmodule

// File: rtl/dpr_pair_unit.sv
module dpr_pair_unit
    import dpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode64_i,
    input  logic [31:0] insn_i,
    input  logic        dec_valid_i,
    input  logic        wr_en_i,
    input  logic [63:0] wr_data_i,
    input  logic        cmp_valid_i,
    input  logic        cmp_result_i,
    output logic [2:0]  op_o,
    output logic        illegal_o,
    output logic [4:0]  rd1_o,
    output logic [4:0]  rd2_o,
    output logic [4:0]  ra1_o,
    output logic [4:0]  ra2_o,
    output logic [4:0]  rb1_o,
    output logic [4:0]  rb2_o,
    output logic [63:0] src_a_o,
    output logic [63:0] src_b_o,
    output logic        flag_o
);

    localparam int NRD = 4;

    dec_t            dec;
    logic            wr_go, flag_go;
    logic            we    [2];
    logic [IDXW-1:0] waddr [2];
    logic [XLEN-1:0] wdata [2];
    logic [IDXW-1:0] raddr [NRD];
    logic [XLEN-1:0] rdata [NRD];

    dpr_decode i_dec (
        .valid_i  (dec_valid_i),
        .mode64_i (mode64_i),
        .insn_i   (insn_i),
        .dec_o    (dec)
    );

    assign wr_go   = dec.wr_pair && wr_en_i;
    assign flag_go = dec.wr_flag && cmp_valid_i;

    // port 0 carries the low half to the first register, port 1 the high half
    assign we[0]    = wr_go;
    assign we[1]    = wr_go;
    assign waddr[0] = dec.rd1;
    assign waddr[1] = dec.rd2;
    assign wdata[0] = wr_data_i[XLEN-1:0];
    assign wdata[1] = wr_data_i[DLEN-1:XLEN];

    assign raddr[0] = dec.ra1;
    assign raddr[1] = dec.ra2;
    assign raddr[2] = dec.rb1;
    assign raddr[3] = dec.rb2;

    dpr_regfile #(.NRD(NRD), .NWR(2)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    assign src_a_o   = {rdata[1], rdata[0]};
    assign src_b_o   = {rdata[3], rdata[2]};
    assign op_o      = dec.op;
    assign illegal_o = dec.illegal;
    assign rd1_o     = dec.rd1;
    assign rd2_o     = dec.rd2;
    assign ra1_o     = dec.ra1;
    assign ra2_o     = dec.ra2;
    assign rb1_o     = dec.rb1;
    assign rb2_o     = dec.rb2;

    always_ff @(posedge clk) begin
        if (rst)          flag_o <= 1'b0;
        else if (flag_go) flag_o <= cmp_result_i;
    end

    // record of the previous cycle's low-half write, for the visibility check
    logic            pw_v;
    logic [IDXW-1:0] pw_addr;
    logic [XLEN-1:0] pw_data;
    always_ff @(posedge clk) begin
        if (rst) begin
            pw_v <= 1'b0; pw_addr <= '0; pw_data <= '0;
        end else begin
            pw_v <= wr_go && (dec.rd1 != '0); pw_addr <= dec.rd1; pw_data <= wr_data_i[XLEN-1:0];
        end
    end

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_go |=> $stable(flag_o));

    a_r8_zero_reads: assert property (@(posedge clk) disable iff (rst)
        (ra1_o == '0) |-> (src_a_o[XLEN-1:0] == '0));

    a_r10_write_visible: assert property (@(posedge clk) disable iff (rst)
        (pw_v && !wr_go && ra1_o == pw_addr) |-> (src_a_o[XLEN-1:0] == pw_data));

    a_r4_pair_step: assert property (@(posedge clk) disable iff (rst)
        (!mode64_i && (op_o == OP_ADD || op_o == OP_SUB)) |->
        ((rd2_o - rd1_o == 5'd1 || rd2_o - rd1_o == 5'd2) &&
         (ra2_o - ra1_o == 5'd1 || ra2_o - ra1_o == 5'd2) &&
         (rb2_o - rb1_o == 5'd1 || rb2_o - rb1_o == 5'd2)));

    a_r7_second_zero: assert property (@(posedge clk) disable iff (rst)
        (mode64_i && op_o != OP_NONE) |-> (rd2_o == '0 && ra2_o == '0 && rb2_o == '0));

    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (op_o == OP_NONE) ##1 $stable(flag_o));

endmodule

// File: tb/test_dpr_pair_unit.sv
module test_dpr_pair_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode64_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic        dec_valid_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [63:0] wr_data_i = '0;
    logic        cmp_valid_i = 1'b0;
    logic        cmp_result_i = 1'b0;
    logic [2:0]  op_o;
    logic        illegal_o;
    logic [4:0]  rd1_o, rd2_o, ra1_o, ra2_o, rb1_o, rb2_o;
    logic [63:0] src_a_o, src_b_o;
    logic        flag_o;

    always #10 clk = ~clk;   // 50 MHz

    dpr_pair_unit i_dpr_pair_unit (
        .clk(clk), .rst(rst), .mode64_i(mode64_i), .insn_i(insn_i),
        .dec_valid_i(dec_valid_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .cmp_valid_i(cmp_valid_i), .cmp_result_i(cmp_result_i),
        .op_o(op_o), .illegal_o(illegal_o),
        .rd1_o(rd1_o), .rd2_o(rd2_o), .ra1_o(ra1_o), .ra2_o(ra2_o),
        .rb1_o(rb1_o), .rb2_o(rb2_o),
        .src_a_o(src_a_o), .src_b_o(src_b_o), .flag_o(flag_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] mdl [32];
    logic        exp_flag = 1'b0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [7:0] fn, int d, int a, int b, logic [2:0] st);
        return {6'h32, 5'(d), 5'(a), 5'(b), st, fn};
    endfunction

    function automatic logic [63:0] pat(int i);
        return {32'(i) * 32'h0F1E_2D3C + 32'h0000_0007, (32'(i) * 32'h3C2D_1E0F) ^ 32'h5A5A_5A5A};
    endfunction

    function automatic int nxt(int first, int st);
        return mode64_i ? 0 : first + 1 + st;
    endfunction

    function automatic logic [63:0] opnd(int first, int st);
        return {mode64_i ? 32'h0 : mdl[first + 1 + st], mdl[first]};
    endfunction

    task automatic cyc;
        @(posedge clk);
        @(negedge clk);
    endtask

    // write pair through an add with write enable (R3, R4, R7, R8, R10, R11)
    task automatic wr_pair(int d, int st, logic [63:0] data);
        int  d2;
        logic bad;
        d2  = nxt(d, st);
        bad = !mode64_i && d2 > 31;
        insn_i = mk(8'h10, d, 0, 0, {st[0], 2'b00});
        dec_valid_i = 1'b1; wr_en_i = 1'b1; wr_data_i = data;
        #2;
        chk(bad ? "R11 overflow illegal" : "R4 write legal", {63'b0, illegal_o}, {63'b0, bad});
        if (!bad) begin
            chk("R2 dest first index", {59'b0, rd1_o}, 64'(d));
            chk("R4 dest second index", {59'b0, rd2_o}, 64'(d2));
        end
        cyc();
        if (!bad) begin
            if (d != 0) mdl[d] = data[31:0];
            if (!mode64_i) mdl[d2] = data[63:32];
        end
        wr_en_i = 1'b0; dec_valid_i = 1'b0;
    endtask

    // read two operands through add/subtract with no write (R1..R4, R7, R11)
    task automatic rd_chk(int a, int sa, int b, int sb, logic [7:0] fn);
        int  a2, b2;
        logic bad;
        a2  = nxt(a, sa);
        b2  = nxt(b, sb);
        bad = !mode64_i && (a2 > 31 || b2 > 31);
        insn_i = mk(fn, 0, a, b, {1'b0, sa[0], sb[0]});
        dec_valid_i = 1'b1; wr_en_i = 1'b0;
        #2;
        chk("R11 read illegal flag", {63'b0, illegal_o}, {63'b0, bad});
        if (bad) begin
            chk("R11 illegal op none", {61'b0, op_o}, 64'd0);
        end else begin
            chk("R1 op code", {61'b0, op_o}, (fn == 8'h10) ? 64'd1 : 64'd2);
            chk("R2 A first index", {59'b0, ra1_o}, 64'(a));
            chk("R4 A second index", {59'b0, ra2_o}, 64'(a2));
            chk("R4 B second index", {59'b0, rb2_o}, 64'(b2));
            chk("R3 source A", src_a_o, opnd(a, sa));
            chk("R3 source B", src_b_o, opnd(b, sb));
        end
        cyc();
        dec_valid_i = 1'b0;
    endtask

    // comparison; wr_en high must not write (R5, R9)
    task automatic cmp_op(logic [7:0] fn, int d, int a, int sa, int b, int sb, logic [2:0] st, logic cv);
        logic bad, res;
        logic [63:0] ea, eb;
        bad = st[2];
        insn_i = mk(fn, d, a, b, st);
        dec_valid_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 64'hDEAD_BEEF_CAFE_F00D;
        ea = opnd(a, sa); eb = opnd(b, sb);
        res = (fn == 8'h18) ? (ea == eb) : (ea != eb);
        cmp_valid_i = cv; cmp_result_i = res;
        #2;
        chk("R5 compare illegal flag", {63'b0, illegal_o}, {63'b0, bad});
        if (!bad) begin
            chk("R1 compare op", {61'b0, op_o}, (fn == 8'h18) ? 64'd3 : 64'd4);
            chk("R5 compare dest index zero", {54'b0, rd1_o, rd2_o}, 64'd0);
            chk("R5 compare source A", src_a_o, ea);
            chk("R5 compare source B", src_b_o, eb);
        end
        cyc();
        if (!bad && cv) exp_flag = res;
        chk("R9 flag after compare", {63'b0, flag_o}, {63'b0, exp_flag});
        dec_valid_i = 1'b0; wr_en_i = 1'b0; cmp_valid_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) cyc();
        rst = 1'b0;
        #2;
        chk("R12 flag reset", {63'b0, flag_o}, 64'd0);
        chk("R1 idle op", {61'b0, op_o}, 64'd0);
        cyc();
        rd_chk(5, 0, 9, 1, 8'h10);    // R12: all zero after reset

        // R1: other major opcode is ignored
        insn_i = {6'h31, 26'h0000010}; dec_valid_i = 1'b1; #2;
        chk("R1 foreign major op", {61'b0, op_o}, 64'd0);
        chk("R1 foreign major not illegal", {63'b0, illegal_o}, 64'd0);
        cyc(); dec_valid_i = 1'b0;

        // fill sweep: every destination with both steps (R4, R8, R11)
        for (int d = 0; d < 32; d++)
            for (int s = 0; s < 2; s++) wr_pair(d, s, pat(d * 2 + s + 1));
        // R8: register 0 reads zero after its write attempt
        chk("R8 reg0 stays zero", {32'b0, mdl[0]}, 64'd0);
        rd_chk(0, 0, 1, 0, 8'h10);

        // read sweep (R2, R3, R4)
        for (int a = 0; a < 32; a++)
            for (int s = 0; s < 2; s++)
                rd_chk(a, s, (a * 5 + 7) % 32, 1 - s, (a % 2 == 1) ? 8'h11 : 8'h10);

        // R10: same-cycle bypass, both halves written at one edge
        insn_i = mk(8'h10, 9, 9, 10, 3'b000); dec_valid_i = 1'b1;
        wr_en_i = 1'b1; wr_data_i = 64'h1234_5678_9ABC_DEF0; #2;
        chk("R10 bypass source A", src_a_o, 64'h1234_5678_9ABC_DEF0);
        chk("R10 bypass source B low", src_b_o[31:0], 64'h1234_5678);
        cyc();
        mdl[9] = 32'h9ABC_DEF0; mdl[10] = 32'h1234_5678;
        wr_en_i = 1'b0; dec_valid_i = 1'b0;
        rd_chk(9, 0, 8, 1, 8'h10);

        // R5, R9: comparisons
        cmp_op(8'h18, 6, 9, 0, 9, 0, 3'b000, 1'b1);   // equal -> 1
        cmp_op(8'h19, 6, 9, 0, 9, 0, 3'b000, 1'b1);   // not-equal on equal -> 0
        cmp_op(8'h19, 6, 4, 1, 12, 0, 3'b010, 1'b1);  // differ -> 1
        cmp_op(8'h18, 6, 4, 1, 12, 0, 3'b010, 1'b0);  // no valid: flag held
        cmp_op(8'h18, 6, 9, 0, 9, 0, 3'b100, 1'b1);   // bit 10 set: illegal
        chk("R11 illegal compare keeps flag", {63'b0, flag_o}, 64'd1);
        // R9: non-compare with strobe high leaves flag
        insn_i = mk(8'h10, 0, 3, 4, 3'b000); dec_valid_i = 1'b1;
        cmp_valid_i = 1'b1; cmp_result_i = 1'b0;
        cyc();
        chk("R9 flag holds on add", {63'b0, flag_o}, 64'd1);
        cmp_valid_i = 1'b0; dec_valid_i = 1'b0;
        rd_chk(6, 0, 6, 1, 8'h10);                     // R5: no write to reg 6..8

        // R6: conversions
        insn_i = mk(8'h14, 14, 3, 0, 3'b110); dec_valid_i = 1'b1;
        wr_en_i = 1'b1; wr_data_i = 64'hA0A0_0001_B0B0_0002; #2;
        chk("R6 itof op", {61'b0, op_o}, 64'd5);
        chk("R6 itof dest second", {59'b0, rd2_o}, 64'd16);
        chk("R6 itof source A", src_a_o, opnd(3, 1));
        chk("R6 itof source B zero", src_b_o, 64'd0);
        cyc();
        mdl[14] = 32'hB0B0_0002; mdl[16] = 32'hA0A0_0001;
        insn_i = mk(8'h15, 20, 14, 0, 3'b000); #2;
        chk("R6 ftoi op", {61'b0, op_o}, 64'd6);
        chk("R6 ftoi source A", src_a_o, opnd(14, 0));
        cyc();
        mdl[20] = 32'hB0B0_0002; mdl[21] = 32'hA0A0_0001;
        insn_i = mk(8'h15, 22, 14, 2, 3'b000); #2;
        chk("R6 ftoi B field nonzero illegal", {63'b0, illegal_o}, 64'd1);
        cyc();
        insn_i = mk(8'h14, 22, 14, 0, 3'b001); #2;
        chk("R6 itof bit8 illegal", {63'b0, illegal_o}, 64'd1);
        cyc();
        // R11: unknown function with write enable
        insn_i = mk(8'h12, 24, 1, 2, 3'b000); #2;
        chk("R11 unknown fn illegal", {63'b0, illegal_o}, 64'd1);
        chk("R11 unknown fn op none", {61'b0, op_o}, 64'd0);
        cyc();
        wr_en_i = 1'b0; dec_valid_i = 1'b0;
        rd_chk(14, 1, 20, 0, 8'h10);
        rd_chk(22, 0, 24, 0, 8'h11);

        // R7: 64-bit-register mode
        mode64_i = 1'b1;
        rd_chk(5, 0, 17, 0, 8'h10);
        wr_pair(26, 0, 64'hFFFF_0000_1111_2222);
        mode64_i = 1'b0;
        rd_chk(26, 0, 25, 0, 8'h10);                   // reg 27 untouched
        mode64_i = 1'b1;
        insn_i = mk(8'h10, 2, 3, 4, 3'b010); dec_valid_i = 1'b1; #2;
        chk("R7 step bit in 64-bit mode illegal", {63'b0, illegal_o}, 64'd1);
        cyc();
        dec_valid_i = 1'b0; mode64_i = 1'b0;

        // R12: reset clears again
        rst = 1'b1; cyc(); rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        exp_flag = 1'b0;
        #2;
        chk("R12 flag cleared", {63'b0, flag_o}, 64'd0);
        rd_chk(9, 0, 14, 1, 8'h10);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule